// File: doc/BRIEF.md
# UART Control and Channel Mode Router

This block holds the control and mode settings of a serial controller and acts on them. From the control word it derives a receiver enable, a transmitter enable and a break request. It also issues one-cycle pulses that empty the receive FIFO, empty the transmit FIFO or restart the receive timeout. From the mode word it derives the frame format fields that the serializer and deserializer need, and it selects one of four channel modes.

The channel mode decides where bytes go. The two byte sources are a received-byte strobe from the line side and a data write strobe from the host. The two destinations are the receive FIFO and the transmitter. Every delivered byte appears as a registered push strobe with its data, one clock after the source strobe. A byte bound for a direction that is not active is dropped without any flag. The serializer, the deserializer and the FIFO storage sit outside this block.

Top module: `uart_chan_ctl`

## Requirements
- R1: After reset the receiver and transmitter are inactive, no break is requested and no push or pulse is asserted. The frame outputs show 8 data bits, even parity enabled, two stop bits, the undivided clock and normal channel mode (0).
- R2: In the control word, bit 2 enables receive and bit 3 disables it; bit 4 enables transmit and bit 5 disables it. `rx_en` and `tx_en` are high only while the enable bit is 1 and the disable bit is 0, so disable wins.
- R3: A control write with bit 0 (receive FIFO reset) or bit 1 (transmit FIFO reset) set raises `rxf_rst` or `txf_rst` for exactly the one cycle after the write. The bit then clears itself, and all other control bits keep their written values.
- R4: `brk_req` is high only while control bit 7 (start break) is 1 and control bit 8 (stop break) is 0.
- R5: Control bit 6 (restart timeout) gives a one-cycle `tmo_restart` pulse after the write that sets it, and then clears itself.
- R6: Mode word fields are decoded as follows. Bits [2:1] set the character length (3 gives 6 bits, 2 gives 7 bits, 0 or 1 gives 8 bits). Bits [5:3] set parity (0 gives even, 1 gives odd, any other value gives none). Bits [7:6] set the stop bits (3 gives one, any other value gives two). Bit 0 selects the input clock divided by 8. Bits [9:8] set the channel mode: 0 normal, 1 echo, 2 local loopback, 3 remote loopback.
- R7: A line byte is pushed to the receive FIFO in normal and echo modes, and to the transmitter in echo and remote loopback modes. Each push happens one cycle after the strobe and carries the same byte.
- R8: A host byte is pushed to the transmitter in normal mode and to the receive FIFO in local loopback mode, one cycle after the strobe. In echo and remote loopback modes it is dropped.
- R9: A push toward an inactive direction is dropped, and no push occurs in a cycle that has no source strobe.
- R10: A write with `reg_sel` = 0 targets the control word and with `reg_sel` = 1 targets the mode word. A write to one leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control word, 1 selects mode word |
| reg_wdata | input | REG_W | Register write data |
| line_vld | input | 1 | Received byte strobe from the line side |
| line_byte | input | DATA_W | Received byte |
| host_wr | input | 1 | Host data write strobe |
| host_byte | input | DATA_W | Host data byte |
| rxf_push | output | 1 | Push into the receive FIFO |
| rxf_data | output | DATA_W | Byte for the receive FIFO |
| txp_push | output | 1 | Push toward the transmitter |
| txp_data | output | DATA_W | Byte for the transmitter |
| rx_en | output | 1 | Receive direction active |
| tx_en | output | 1 | Transmit direction active |
| rxf_rst | output | 1 | One-cycle receive FIFO reset |
| txf_rst | output | 1 | One-cycle transmit FIFO reset |
| tmo_restart | output | 1 | One-cycle receive timeout restart |
| brk_req | output | 1 | Break request |
| char_bits | output | 4 | Character length in bits |
| parity_en | output | 1 | Parity bit present |
| parity_odd | output | 1 | Odd parity when parity_en |
| stop_two | output | 1 | Two stop bits |
| clk_div8 | output | 1 | Input clock divided by 8 |
| chan_mode | output | 2 | Channel mode |

## Verification
The assertions assume that each strobe is a single-cycle pulse sampled at the rising edge. They also assume that routing uses the settings that were in force before any register write in the same cycle, so a strobe that coincides with a write follows the old mode and enables. The stimulus changes every input on the falling edge and never writes a register in the same cycle as a byte strobe, so the settings seen by each byte are unambiguous. Line and host strobes are sometimes raised together, because in every mode their destinations differ and no push can have two sources.

// File: rtl/uart_chan_pkg.sv
package uart_chan_pkg;

  localparam int CTL_W  = 9;
  localparam int MODE_W = 10;

  localparam int B_RXRST  = 0;
  localparam int B_TXRST  = 1;
  localparam int B_RXEN   = 2;
  localparam int B_RXDIS  = 3;
  localparam int B_TXEN   = 4;
  localparam int B_TXDIS  = 5;
  localparam int B_TMORST = 6;
  localparam int B_BRKON  = 7;
  localparam int B_BRKOFF = 8;

  localparam logic [CTL_W-1:0] CTL_RESET   = 9'h128;
  localparam logic [CTL_W-1:0] CTL_SELFCLR = (9'd1 << B_RXRST) | (9'd1 << B_TXRST)
                                           | (9'd1 << B_TMORST);

  typedef enum logic [1:0] {
    CH_NORMAL = 2'd0,
    CH_ECHO   = 2'd1,
    CH_LLOOP  = 2'd2,
    CH_RLOOP  = 2'd3
  } chan_mode_e;

  function automatic logic [3:0] char_len_of(input logic [1:0] code);
    case (code)
      2'd3:    char_len_of = 4'd6;
      2'd2:    char_len_of = 4'd7;
      default: char_len_of = 4'd8;
    endcase
  endfunction

  function automatic logic parity_on(input logic [2:0] code);
    parity_on = (code == 3'd0) || (code == 3'd1);
  endfunction

  function automatic logic two_stops(input logic [1:0] code);
    two_stops = (code != 2'd3);
  endfunction

  function automatic logic dir_active(input logic en, input logic dis);
    dir_active = en && !dis;
  endfunction

endpackage

// File: rtl/uart_ctl_reg.sv
module uart_ctl_reg
  import uart_chan_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic             rx_en,
  output logic             tx_en,
  output logic             rxf_rst,
  output logic             txf_rst,
  output logic             tmo_restart,
  output logic             brk_req
);

  logic [CTL_W-1:0] ctl_q;

  // Each control bit is its own flop; self-clearing bits drop back to zero
  // on every cycle without a write.
  for (genvar b = 0; b < CTL_W; b++) begin : g_bit
    if (CTL_SELFCLR[b]) begin : g_pulse
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ctl_q[b] <= CTL_RESET[b];
        else if (wr_en) ctl_q[b] <= wdata[b];
        else            ctl_q[b] <= 1'b0;
      end
    end else begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ctl_q[b] <= CTL_RESET[b];
        else if (wr_en) ctl_q[b] <= wdata[b];
      end
    end
  end

  assign rx_en       = dir_active(ctl_q[B_RXEN], ctl_q[B_RXDIS]);
  assign tx_en       = dir_active(ctl_q[B_TXEN], ctl_q[B_TXDIS]);
  assign brk_req     = ctl_q[B_BRKON] && !ctl_q[B_BRKOFF];
  assign rxf_rst     = ctl_q[B_RXRST];
  assign txf_rst     = ctl_q[B_TXRST];
  assign tmo_restart = ctl_q[B_TMORST];

  // R3: reset pulses last one cycle unless rewritten
  a_r3_rxrst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_rst && !(wr_en && wdata[B_RXRST]) |=> !rxf_rst);
  a_r3_txrst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    txf_rst && !(wr_en && wdata[B_TXRST]) |=> !txf_rst);
  // R5: timeout restart is a pulse too
  a_r5_tmo_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_restart && !(wr_en && wdata[B_TMORST]) |=> !tmo_restart);
  // R2: enables hold while no write occurs
  a_r2_en_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rx_en) && $stable(tx_en) && $stable(brk_req));

endmodule

// File: rtl/uart_mode_reg.sv
module uart_mode_reg
  import uart_chan_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [3:0]       char_bits,
  output logic             parity_en,
  output logic             parity_odd,
  output logic             stop_two,
  output logic             clk_div8,
  output chan_mode_e       mode
);

  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= '0;
    else if (wr_en) mode_q <= wdata[MODE_W-1:0];
  end

  assign char_bits  = char_len_of(mode_q[2:1]);
  assign parity_en  = parity_on(mode_q[5:3]);
  assign parity_odd = (mode_q[5:3] == 3'd1);
  assign stop_two   = two_stops(mode_q[7:6]);
  assign clk_div8   = mode_q[0];
  assign mode       = chan_mode_e'(mode_q[9:8]);

  // R10: the mode word only moves on its own write
  a_r10_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mode) && $stable(char_bits) && $stable(stop_two));

endmodule

// File: rtl/uart_chan_route.sv
module uart_chan_route
  import uart_chan_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  chan_mode_e        mode,
  input  logic              rx_en,
  input  logic              tx_en,
  input  logic              line_vld,
  input  logic [DATA_W-1:0] line_byte,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_byte,
  output logic              rxf_push,
  output logic [DATA_W-1:0] rxf_data,
  output logic              txp_push,
  output logic [DATA_W-1:0] txp_data
);

  localparam int N_DIR  = 2;
  localparam int DIR_RX = 0;
  localparam int DIR_TX = 1;

  // Named routing events, visible to assertions
  logic line_to_rx, line_to_tx, host_to_rx, host_to_tx;

  assign line_to_rx = line_vld && rx_en && (mode == CH_NORMAL || mode == CH_ECHO);
  assign line_to_tx = line_vld && tx_en && (mode == CH_ECHO   || mode == CH_RLOOP);
  assign host_to_rx = host_wr  && rx_en && (mode == CH_LLOOP);
  assign host_to_tx = host_wr  && tx_en && (mode == CH_NORMAL);

  logic [N_DIR-1:0]             go;
  logic [N_DIR-1:0][DATA_W-1:0] pick;
  logic [N_DIR-1:0]             push_q;
  logic [N_DIR-1:0][DATA_W-1:0] data_q;

  assign go[DIR_RX]   = line_to_rx || host_to_rx;
  assign go[DIR_TX]   = line_to_tx || host_to_tx;
  assign pick[DIR_RX] = line_to_rx ? line_byte : host_byte;
  assign pick[DIR_TX] = line_to_tx ? line_byte : host_byte;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        push_q[d] <= 1'b0;
        data_q[d] <= '0;
      end else begin
        push_q[d] <= go[d];
        if (go[d]) data_q[d] <= pick[d];
      end
    end
  end

  assign rxf_push = push_q[DIR_RX];
  assign rxf_data = data_q[DIR_RX];
  assign txp_push = push_q[DIR_TX];
  assign txp_data = data_q[DIR_TX];

  // R7: line byte reaches the receive FIFO in normal/echo
  a_r7_line_rx: assert property (@(posedge clk) disable iff (!rst_n)
    line_vld && rx_en && (mode == CH_NORMAL || mode == CH_ECHO)
    |=> rxf_push && rxf_data == $past(line_byte));
  // R7: line byte reaches the transmitter in echo/remote loopback
  a_r7_line_tx: assert property (@(posedge clk) disable iff (!rst_n)
    line_vld && tx_en && (mode == CH_ECHO || mode == CH_RLOOP)
    |=> txp_push && txp_data == $past(line_byte));
  // R8: host byte reaches the transmitter in normal mode
  a_r8_host_tx: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && tx_en && mode == CH_NORMAL |=> txp_push && txp_data == $past(host_byte));
  // R9: no push into an inactive direction, none without a strobe
  a_r9_rx_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rxf_push);
  a_r9_tx_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !txp_push);
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !line_vld && !host_wr |=> !rxf_push && !txp_push);

endmodule

// File: rtl/uart_chan_ctl.sv
module uart_chan_ctl
  import uart_chan_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              line_vld,
  input  logic [DATA_W-1:0] line_byte,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_byte,
  output logic              rxf_push,
  output logic [DATA_W-1:0] rxf_data,
  output logic              txp_push,
  output logic [DATA_W-1:0] txp_data,
  output logic              rx_en,
  output logic              tx_en,
  output logic              rxf_rst,
  output logic              txf_rst,
  output logic              tmo_restart,
  output logic              brk_req,
  output logic [3:0]        char_bits,
  output logic              parity_en,
  output logic              parity_odd,
  output logic              stop_two,
  output logic              clk_div8,
  output logic [1:0]        chan_mode
);

  logic       ctl_wr, mode_wr;
  chan_mode_e mode;

  assign ctl_wr  = reg_wr && !reg_sel;
  assign mode_wr = reg_wr &&  reg_sel;

  uart_ctl_reg #(.REG_W(REG_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr), .wdata(reg_wdata),
    .rx_en(rx_en), .tx_en(tx_en), .rxf_rst(rxf_rst), .txf_rst(txf_rst),
    .tmo_restart(tmo_restart), .brk_req(brk_req)
  );

  uart_mode_reg #(.REG_W(REG_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr_en(mode_wr), .wdata(reg_wdata),
    .char_bits(char_bits), .parity_en(parity_en), .parity_odd(parity_odd),
    .stop_two(stop_two), .clk_div8(clk_div8), .mode(mode)
  );

  uart_chan_route #(.DATA_W(DATA_W)) u_route (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rx_en(rx_en), .tx_en(tx_en),
    .line_vld(line_vld), .line_byte(line_byte),
    .host_wr(host_wr), .host_byte(host_byte),
    .rxf_push(rxf_push), .rxf_data(rxf_data),
    .txp_push(txp_push), .txp_data(txp_data)
  );

  assign chan_mode = mode;

  // R10: a mode write never disturbs the control outputs
  a_r10_sel_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> $stable(rx_en) && $stable(tx_en) && !rxf_rst && !txf_rst);

endmodule

// File: tb/tb_uart_chan_ctl.sv
module tb_uart_chan_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int REG_W  = 16;
  localparam int DATA_W = 8;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_sel = 0;
  logic [REG_W-1:0] reg_wdata = '0;
  logic line_vld = 0, host_wr = 0;
  logic [DATA_W-1:0] line_byte = '0, host_byte = '0;
  logic rxf_push, txp_push, rx_en, tx_en, rxf_rst, txf_rst, tmo_restart, brk_req;
  logic [DATA_W-1:0] rxf_data, txp_data;
  logic [3:0] char_bits;
  logic parity_en, parity_odd, stop_two, clk_div8;
  logic [1:0] chan_mode;

  uart_chan_ctl #(.REG_W(REG_W), .DATA_W(DATA_W)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  typedef struct { logic rx_p; logic [7:0] rx_d; logic tx_p; logic [7:0] tx_d; string req; } exp_t;
  exp_t sb[$];

  // bench-side model of the settings
  logic m_rx = 0, m_tx = 0;
  logic [1:0] m_mode = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(logic [8:0] v);
    @(negedge clk);
    reg_wr = 1; reg_sel = 0; reg_wdata = REG_W'(v);
    m_rx = v[2] && !v[3];
    m_tx = v[4] && !v[5];
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic wr_mode(logic [9:0] v);
    @(negedge clk);
    reg_wr = 1; reg_sel = 1; reg_wdata = REG_W'(v);
    m_mode = v[9:8];
    @(negedge clk);
    reg_wr = 0;
  endtask

  // driver: one stimulus cycle, expected pushes queued for the monitor
  task automatic drive(logic lv, logic [7:0] lb, logic hw, logic [7:0] hb, string req);
    exp_t e;
    @(negedge clk);
    line_vld = lv; line_byte = lb; host_wr = hw; host_byte = hb;
    e.req = req;
    e.rx_p = 0; e.rx_d = 0; e.tx_p = 0; e.tx_d = 0;
    if (m_rx && lv && (m_mode == 0 || m_mode == 1)) begin e.rx_p = 1; e.rx_d = lb; end
    if (m_rx && hw && m_mode == 2)                 begin e.rx_p = 1; e.rx_d = hb; end
    if (m_tx && lv && (m_mode == 1 || m_mode == 3)) begin e.tx_p = 1; e.tx_d = lb; end
    if (m_tx && hw && m_mode == 0)                 begin e.tx_p = 1; e.tx_d = hb; end
    sb.push_back(e);
    @(negedge clk);
    line_vld = 0; host_wr = 0;
  endtask

  // monitor: compare each result cycle against the scoreboard
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk({e.req, " rx push"}, rxf_push, e.rx_p);
      chk({e.req, " tx push"}, txp_push, e.tx_p);
      if (e.rx_p) chk({e.req, " rx data"}, rxf_data, e.rx_d);
      if (e.tx_p) chk({e.req, " tx data"}, txp_data, e.tx_d);
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rx_en", rx_en, 0);
    chk("R1 tx_en", tx_en, 0);
    chk("R1 brk", brk_req, 0);
    chk("R1 pulses", {rxf_rst, txf_rst, tmo_restart}, 0);
    chk("R1 pushes", {rxf_push, txp_push}, 0);
    chk("R1 char_bits", char_bits, 8);
    chk("R1 parity", {parity_en, parity_odd}, 2'b10);
    chk("R1 stop_two", stop_two, 1);
    chk("R1 div8", clk_div8, 0);
    chk("R1 mode", chan_mode, 0);

    // R9: both directions disabled, bytes dropped
    drive(1, 8'h11, 1, 8'h22, "R9 disabled");

    // R2 enable/disable pairs
    wr_ctl(9'h004);
    chk("R2 rx only rx", rx_en, 1); chk("R2 rx only tx", tx_en, 0);
    wr_ctl(9'h00C);
    chk("R2 rx dis wins", rx_en, 0);
    wr_ctl(9'h030);
    chk("R2 tx dis wins", tx_en, 0);
    wr_ctl(9'h014);
    chk("R2 both rx", rx_en, 1); chk("R2 both tx", tx_en, 1);

    // R3 self-clearing resets
    @(negedge clk);
    reg_wr = 1; reg_sel = 0; reg_wdata = 16'h0017;
    @(negedge clk);
    reg_wr = 0;
    chk("R3 rxf_rst pulse", rxf_rst, 1);
    chk("R3 txf_rst pulse", txf_rst, 1);
    @(negedge clk);
    chk("R3 rxf_rst clear", rxf_rst, 0);
    chk("R3 txf_rst clear", txf_rst, 0);
    chk("R3 enables kept", {rx_en, tx_en}, 2'b11);

    // R5 timeout restart pulse
    @(negedge clk);
    reg_wr = 1; reg_sel = 0; reg_wdata = 16'h0054;
    @(negedge clk);
    reg_wr = 0;
    chk("R5 tmo pulse", tmo_restart, 1);
    @(negedge clk);
    chk("R5 tmo clear", tmo_restart, 0);

    // R4 break
    wr_ctl(9'h094); chk("R4 start", brk_req, 1);
    wr_ctl(9'h194); chk("R4 both set", brk_req, 0);
    wr_ctl(9'h114); chk("R4 stop only", brk_req, 0);

    // R6 / R10 mode decoding
    wr_mode(10'h006); chk("R6 6 bits", char_bits, 6);
    chk("R10 ctl kept", {rx_en, tx_en}, 2'b11);
    wr_mode(10'h004); chk("R6 7 bits", char_bits, 7);
    wr_mode(10'h002); chk("R6 8 bits", char_bits, 8);
    wr_mode(10'h008); chk("R6 odd", {parity_en, parity_odd}, 2'b11);
    wr_mode(10'h020); chk("R6 none", parity_en, 0);
    wr_mode(10'h0C0); chk("R6 one stop", stop_two, 0);
    wr_mode(10'h080); chk("R6 two stop", stop_two, 1);
    wr_mode(10'h001); chk("R6 div8", clk_div8, 1);
    wr_mode(10'h300); chk("R6 rloop", chan_mode, 3);
    wr_ctl(9'h014);   chk("R10 mode kept", chan_mode, 3);

    // R7 / R8 routing in every mode, both directions active
    for (int md = 0; md < 4; md++) begin
      wr_mode(10'(md << 8));
      drive(1, 8'hA0 + 8'(md), 0, 8'h00, "R7 line");
      drive(0, 8'h00, 1, 8'hB0 + 8'(md), "R8 host");
      drive(1, 8'hC0 + 8'(md), 1, 8'hD0 + 8'(md), "R7 R8 both");
      drive(0, 8'h5A, 0, 8'hA5, "R9 idle");
    end

    // R9 one direction inactive
    wr_ctl(9'h034); // rx on, tx disabled
    wr_mode(10'h100);
    drive(1, 8'h3C, 0, 8'h00, "R9 echo tx off");
    wr_mode(10'h000);
    drive(0, 8'h00, 1, 8'h4D, "R9 normal tx off");
    wr_ctl(9'h01C); // rx disabled, tx on
    wr_mode(10'h200);
    drive(0, 8'h00, 1, 8'h6E, "R9 lloop rx off");
    wr_mode(10'h100);
    drive(1, 8'h7F, 0, 8'h00, "R9 echo rx off");

    repeat (3) @(negedge clk);
    chk("scoreboard drained", sb.size(), 0);
    done = 1;
    finish_run();
  end
endmodule